// File: doc/BRIEF.md
# Configurable Output Cell for a Programmable Sum-of-Products Array

This block is one output cell of a small universal programmable logic array. It receives the product terms that the AND plane produces for this cell, plus the device's shared clock and shared active-low output-enable pins, the value seen on its own pad, and a handful of configuration bits. It drives a tri-state pad model (a data bit plus a drive enable) and a feedback bit that returns to the AND plane.

Two configuration bits that are common to every cell of the device and one bit that belongs to this cell alone choose one of four behaviours: a clocked output, a plain combinational output, a combinational bidirectional pin whose drive is gated by one product term, or a pure input. The choice steers four multiplexers: the one that picks which terms form the sum, the one that picks the pad data, the one that picks the drive enable and the one that picks the feedback source. A polarity bit inverts the sum. The flip-flop is cleared by the power-up reset and can be loaded with any value through a test preload path.

Top module: `pal_macrocell`

## Requirements
- R1: The mode is decoded from {glb_seq_i, glb_wide_i, cell_sel_i}: 100 gives clocked output, 101 and 010 give bidirectional, 000 gives combinational output, and 011, 001, 110, 111 give dedicated input.
- R2: In clocked output mode the flip-flop captures (OR of all eight product terms) XOR pol_i at each rising clk_i edge, and both pad_o and fb_o show the flip-flop value.
- R3: In clocked output mode pad_oe_o is high exactly when oe_n_i is low.
- R4: In combinational output mode pad_o is (OR of all eight terms) XOR pol_i with no clock delay, pad_oe_o is 1, and oe_n_i has no effect.
- R5: In bidirectional mode pt_i[0] is the drive enable and is excluded from the sum, so pad_o is (OR of pt_i[7:1]) XOR pol_i and pad_oe_o equals pt_i[0].
- R6: In dedicated input mode pad_oe_o and pad_o are 0 whatever the product terms and oe_n_i do.
- R7: In every mode except clocked output, fb_o equals pin_i.
- R8: While por_ni is low the flip-flop is cleared at once, without waiting for a clock edge.
- R9: When preload_en_i is high at a rising clk_i edge the flip-flop takes preload_val_i, and this wins over the sum in that same edge.
- R10: pol_i = 1 inverts the data path of the sum in every driving mode; pol_i = 0 passes it true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared device clock pin |
| por_ni | input | 1 | Power-up reset, active low, asynchronous |
| glb_seq_i | input | 1 | Device-wide mode bit: sequential family |
| glb_wide_i | input | 1 | Device-wide mode bit: wide combinational family |
| cell_sel_i | input | 1 | Per-cell mode bit |
| pol_i | input | 1 | Output polarity, 1 inverts the sum |
| pt_i | input | NUM_PT | Product terms from the AND plane |
| oe_n_i | input | 1 | Shared output-enable pin, active low |
| pin_i | input | 1 | Value present on this cell's pad |
| preload_en_i | input | 1 | Test preload strobe |
| preload_val_i | input | 1 | Test preload value |
| pad_o | output | 1 | Pad drive data |
| pad_oe_o | output | 1 | Pad drive enable |
| fb_o | output | 1 | Feedback to the AND plane |

## Verification
The two functions that can meet in one clock edge are the test preload and the ordinary capture of the sum into the flip-flop. The bench provokes the collision by setting the product terms so that the sum is the opposite of the preload value and raising the preload strobe for that edge, in both directions; the pad must then show the preload value, and on the following edge, with the strobe low, the sum. The power-up clear is also dropped between edges while the flip-flop holds a one, and the pad is judged before any further edge arrives.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;

   typedef enum logic [1:0] {
      MODE_REG     = 2'd0,
      MODE_COMB_OUT = 2'd1,
      MODE_COMB_IO = 2'd2,
      MODE_DED_IN  = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      EN_FROM_PIN  = 2'd0,
      EN_ALWAYS    = 2'd1,
      EN_FROM_TERM = 2'd2,
      EN_NEVER     = 2'd3
   } en_sel_e;

   typedef struct packed {
      logic    sum_skip_term;
      logic    data_from_reg;
      en_sel_e en_sel;
      logic    fb_from_reg;
   } mux_sel_t;

   function automatic mode_e decode_mode(input logic seq, input logic wide, input logic sel);
      mode_e m;
      unique case ({seq, wide, sel})
         3'b100:  m = MODE_REG;
         3'b101:  m = MODE_COMB_IO;
         3'b010:  m = MODE_COMB_IO;
         3'b000:  m = MODE_COMB_OUT;
         default: m = MODE_DED_IN;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
   import pal_mc_pkg::*;
(
   input  logic     glb_seq_i,
   input  logic     glb_wide_i,
   input  logic     cell_sel_i,
   output mode_e    mode_o,
   output mux_sel_t sel_o
);

   mode_e mode_w;

   assign mode_w = decode_mode(glb_seq_i, glb_wide_i, cell_sel_i);
   assign mode_o = mode_w;

   always_comb begin
      sel_o = '{sum_skip_term: 1'b0, data_from_reg: 1'b0,
                en_sel: EN_NEVER, fb_from_reg: 1'b0};
      unique case (mode_w)
         MODE_REG: begin
            sel_o.data_from_reg = 1'b1;
            sel_o.en_sel        = EN_FROM_PIN;
            sel_o.fb_from_reg   = 1'b1;
         end
         MODE_COMB_OUT: begin
            sel_o.en_sel = EN_ALWAYS;
         end
         MODE_COMB_IO: begin
            sel_o.sum_skip_term = 1'b1;
            sel_o.en_sel        = EN_FROM_TERM;
         end
         default: begin
            sel_o.en_sel = EN_NEVER;
         end
      endcase
   end

endmodule

// File: rtl/pal_mc_sum.sv
module pal_mc_sum #(
   parameter int NUM_PT  = 8,
   parameter int OE_IDX  = 0,
   parameter bit TREE_OR = 1'b0
) (
   input  logic [NUM_PT-1:0] pt_i,
   input  logic              skip_term_i,
   output logic              sum_o,
   output logic              oe_term_o
);

   localparam int HALF = NUM_PT / 2;

   logic [NUM_PT-1:0] keep_mask;
   logic [NUM_PT-1:0] gated;

   for (genvar g = 0; g < NUM_PT; g++) begin : g_mask
      if (g == OE_IDX) begin : g_oe
         assign keep_mask[g] = ~skip_term_i;
      end else begin : g_data
         assign keep_mask[g] = 1'b1;
      end
   end

   assign gated     = pt_i & keep_mask;
   assign oe_term_o = pt_i[OE_IDX];

   if (TREE_OR) begin : g_tree
      logic lo_or, hi_or;
      assign lo_or = |gated[HALF-1:0];
      assign hi_or = |gated[NUM_PT-1:HALF];
      assign sum_o = lo_or | hi_or;
   end else begin : g_flat
      assign sum_o = |gated;
   end

endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
   input  logic clk_i,
   input  logic por_ni,
   input  logic d_i,
   input  logic preload_en_i,
   input  logic preload_val_i,
   output logic q_o
);

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         q_o <= 1'b0;
      end else if (preload_en_i) begin
         q_o <= preload_val_i;
      end else begin
         q_o <= d_i;
      end
   end

endmodule

// File: rtl/pal_mc_route.sv
module pal_mc_route
   import pal_mc_pkg::*;
(
   input  mux_sel_t sel_i,
   input  logic     comb_i,
   input  logic     q_i,
   input  logic     oe_term_i,
   input  logic     oe_n_i,
   input  logic     pin_i,
   output logic     pad_o,
   output logic     pad_oe_o,
   output logic     fb_o
);

   logic en_w;

   always_comb begin
      unique case (sel_i.en_sel)
         EN_FROM_PIN:  en_w = ~oe_n_i;
         EN_ALWAYS:    en_w = 1'b1;
         EN_FROM_TERM: en_w = oe_term_i;
         default:      en_w = 1'b0;
      endcase
   end

   assign pad_oe_o = en_w;

   always_comb begin
      if (sel_i.en_sel == EN_NEVER) begin
         pad_o = 1'b0;
      end else if (sel_i.data_from_reg) begin
         pad_o = q_i;
      end else begin
         pad_o = comb_i;
      end
   end

   assign fb_o = sel_i.fb_from_reg ? q_i : pin_i;

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
   import pal_mc_pkg::*;
#(
   parameter int NUM_PT  = 8,
   parameter int OE_IDX  = 0,
   parameter bit TREE_OR = 1'b0
) (
   input  logic              clk_i,
   input  logic              por_ni,
   input  logic              glb_seq_i,
   input  logic              glb_wide_i,
   input  logic              cell_sel_i,
   input  logic              pol_i,
   input  logic [NUM_PT-1:0] pt_i,
   input  logic              oe_n_i,
   input  logic              pin_i,
   input  logic              preload_en_i,
   input  logic              preload_val_i,
   output logic              pad_o,
   output logic              pad_oe_o,
   output logic              fb_o
);

   if (NUM_PT < 2) begin : g_bad_num
      $error("pal_macrocell: NUM_PT must be at least 2");
   end
   if (OE_IDX < 0 || OE_IDX >= NUM_PT) begin : g_bad_idx
      $error("pal_macrocell: OE_IDX out of range");
   end

   mode_e    cell_mode;
   mux_sel_t sel;
   logic     full_sum, io_sum, sum_sel, oe_term, oe_term_unused;
   logic     reg_d, reg_q, comb_val;

   pal_mc_decode u_decode (
      .glb_seq_i  (glb_seq_i),
      .glb_wide_i (glb_wide_i),
      .cell_sel_i (cell_sel_i),
      .mode_o     (cell_mode),
      .sel_o      (sel)
   );

   // Full sum feeds the flip-flop; selected sum feeds the combinational path.
   pal_mc_sum #(.NUM_PT(NUM_PT), .OE_IDX(OE_IDX), .TREE_OR(TREE_OR)) u_sum_full (
      .pt_i        (pt_i),
      .skip_term_i (1'b0),
      .sum_o       (full_sum),
      .oe_term_o   (oe_term_unused)
   );

   pal_mc_sum #(.NUM_PT(NUM_PT), .OE_IDX(OE_IDX), .TREE_OR(TREE_OR)) u_sum_io (
      .pt_i        (pt_i),
      .skip_term_i (1'b1),
      .sum_o       (io_sum),
      .oe_term_o   (oe_term)
   );

   assign sum_sel  = sel.sum_skip_term ? io_sum : full_sum;
   assign comb_val = sum_sel ^ pol_i;
   assign reg_d    = full_sum ^ pol_i;

   pal_mc_reg u_reg (
      .clk_i         (clk_i),
      .por_ni        (por_ni),
      .d_i           (reg_d),
      .preload_en_i  (preload_en_i),
      .preload_val_i (preload_val_i),
      .q_o           (reg_q)
   );

   pal_mc_route u_route (
      .sel_i     (sel),
      .comb_i    (comb_val),
      .q_i       (reg_q),
      .oe_term_i (oe_term),
      .oe_n_i    (oe_n_i),
      .pin_i     (pin_i),
      .pad_o     (pad_o),
      .pad_oe_o  (pad_oe_o),
      .fb_o      (fb_o)
   );

endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk
   import pal_mc_pkg::*;
#(
   parameter int NUM_PT = 8
) (
   input logic              clk_i,
   input logic              por_ni,
   input logic              pol_i,
   input logic [NUM_PT-1:0] pt_i,
   input logic              oe_n_i,
   input logic              pin_i,
   input logic              preload_en_i,
   input logic              preload_val_i,
   input logic              pad_o,
   input logic              pad_oe_o,
   input logic              fb_o,
   input mode_e             cell_mode,
   input logic              reg_q
);

   p_reg_oe_r3: assert property (@(posedge clk_i) disable iff (!por_ni)
      (cell_mode == MODE_REG) |-> (pad_oe_o == !oe_n_i));

   p_reg_fb_r2: assert property (@(posedge clk_i) disable iff (!por_ni)
      (cell_mode == MODE_REG) |-> (fb_o == pad_o && pad_o == reg_q));

   p_capture_r2: assert property (@(posedge clk_i) disable iff (!por_ni)
      (!preload_en_i) |=> (reg_q == $past((|pt_i) ^ pol_i)));

   p_preload_r9: assert property (@(posedge clk_i) disable iff (!por_ni)
      preload_en_i |=> (reg_q == $past(preload_val_i)));

   p_io_enable_r5: assert property (@(posedge clk_i) disable iff (!por_ni)
      (cell_mode == MODE_COMB_IO) |-> (pad_oe_o == pt_i[0]));

   p_combout_en_r4: assert property (@(posedge clk_i) disable iff (!por_ni)
      (cell_mode == MODE_COMB_OUT) |-> pad_oe_o);

   p_dedin_quiet_r6: assert property (@(posedge clk_i) disable iff (!por_ni)
      (cell_mode == MODE_DED_IN) |-> (!pad_oe_o && !pad_o));

   p_pin_fb_r7: assert property (@(posedge clk_i) disable iff (!por_ni)
      (cell_mode != MODE_REG) |-> (fb_o == pin_i));

   p_por_clear_r8: assert property (@(posedge clk_i)
      (!por_ni) |-> (reg_q == 1'b0));

endmodule

bind pal_macrocell pal_macrocell_chk #(.NUM_PT(NUM_PT)) u_chk (
   .clk_i         (clk_i),
   .por_ni        (por_ni),
   .pol_i         (pol_i),
   .pt_i          (pt_i),
   .oe_n_i        (oe_n_i),
   .pin_i         (pin_i),
   .preload_en_i  (preload_en_i),
   .preload_val_i (preload_val_i),
   .pad_o         (pad_o),
   .pad_oe_o      (pad_oe_o),
   .fb_o          (fb_o),
   .cell_mode     (cell_mode),
   .reg_q         (reg_q)
);

// File: tb/pal_macrocell_tb.sv
module pal_macrocell_tb;

   logic       clk_i = 1'b0;
   logic       por_ni = 1'b0;
   logic       glb_seq_i = 1'b1, glb_wide_i = 1'b0, cell_sel_i = 1'b0;
   logic       pol_i = 1'b0;
   logic [7:0] pt_i = 8'h00;
   logic       oe_n_i = 1'b0, pin_i = 1'b0;
   logic       preload_en_i = 1'b0, preload_val_i = 1'b0;
   logic       pad_o, pad_oe_o, fb_o;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   pal_macrocell u_dut (
      .clk_i(clk_i), .por_ni(por_ni), .glb_seq_i(glb_seq_i), .glb_wide_i(glb_wide_i),
      .cell_sel_i(cell_sel_i), .pol_i(pol_i), .pt_i(pt_i), .oe_n_i(oe_n_i),
      .pin_i(pin_i), .preload_en_i(preload_en_i), .preload_val_i(preload_val_i),
      .pad_o(pad_o), .pad_oe_o(pad_oe_o), .fb_o(fb_o)
   );

   always #2 clk_i = ~clk_i;

   function automatic logic or_terms(logic [7:0] v, bit skip0);
      logic r = 1'b0;
      for (int i = 0; i < 8; i++)
         if (!(skip0 && i == 0) && v[i]) r = 1'b1;
      return r;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic set_mode(logic s, logic w, logic c);
      @(negedge clk_i);
      glb_seq_i = s; glb_wide_i = w; cell_sel_i = c;
   endtask

   task automatic t_reset;
      #1;
      chk("R8 reset pad", pad_o, 1'b0);
      chk("R8 reset fb", fb_o, 1'b0);
      @(negedge clk_i); por_ni = 1'b1;
   endtask

   task automatic t_registered;
      logic [7:0] pats [4] = '{8'h00, 8'h80, 8'h00, 8'h11};
      set_mode(1'b1, 1'b0, 1'b0);
      pol_i = 1'b0; oe_n_i = 1'b0;
      foreach (pats[k]) begin
         @(negedge clk_i); pt_i = pats[k]; pin_i = ~pin_i;
         #1;
         @(posedge clk_i); #1;
         chk("R2 reg pad", pad_o, or_terms(pats[k], 1'b0));
         chk("R2 reg fb", fb_o, or_terms(pats[k], 1'b0));
      end
   endtask

   task automatic t_reg_oe;
      set_mode(1'b1, 1'b0, 1'b0);
      oe_n_i = 1'b1; #1;
      chk("R3 oe high disables", pad_oe_o, 1'b0);
      @(negedge clk_i); oe_n_i = 1'b0; #1;
      chk("R3 oe low enables", pad_oe_o, 1'b1);
   endtask

   task automatic t_comb_out;
      set_mode(1'b0, 1'b0, 1'b0);
      pol_i = 1'b0; oe_n_i = 1'b1; pt_i = 8'h01; pin_i = 1'b1; #1;
      chk("R1 R4 comb out data", pad_o, 1'b1);
      chk("R4 comb out en ignores oe_n", pad_oe_o, 1'b1);
      chk("R7 comb out fb", fb_o, 1'b1);
      pt_i = 8'h00; pin_i = 1'b0; #1;
      chk("R4 comb out no terms", pad_o, 1'b0);
      chk("R7 comb out fb low", fb_o, 1'b0);
   endtask

   task automatic t_comb_io;
      for (int m = 0; m < 2; m++) begin
         if (m == 0) set_mode(1'b1, 1'b0, 1'b1);
         else        set_mode(1'b0, 1'b1, 1'b0);
         pol_i = 1'b0; pt_i = 8'h01; pin_i = 1'b1; #1;
         chk("R5 io term0 not in sum", pad_o, 1'b0);
         chk("R5 io enable from term0", pad_oe_o, 1'b1);
         chk("R7 io fb from pin", fb_o, 1'b1);
         pt_i = 8'h40; pin_i = 1'b0; #1;
         chk("R5 io sum of upper terms", pad_o, 1'b1);
         chk("R5 io disabled", pad_oe_o, 1'b0);
         chk("R1 R7 io fb pin low", fb_o, 1'b0);
      end
   endtask

   task automatic t_dedicated;
      logic [2:0] codes [4] = '{3'b011, 3'b001, 3'b110, 3'b111};
      foreach (codes[k]) begin
         set_mode(codes[k][2], codes[k][1], codes[k][0]);
         pt_i = 8'hFF; oe_n_i = 1'b0; pol_i = 1'b1; pin_i = k[0]; #1;
         chk("R1 R6 dedicated no drive", pad_oe_o, 1'b0);
         chk("R6 dedicated pad quiet", pad_o, 1'b0);
         chk("R7 dedicated fb", fb_o, k[0]);
      end
   endtask

   task automatic t_polarity;
      set_mode(1'b0, 1'b0, 1'b0);
      pol_i = 1'b1; pt_i = 8'h00; #1;
      chk("R10 inverted comb none", pad_o, 1'b1);
      pt_i = 8'h20; #1;
      chk("R10 inverted comb some", pad_o, 1'b0);
      set_mode(1'b1, 1'b0, 1'b0);
      oe_n_i = 1'b0; pt_i = 8'h00; pol_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R10 inverted reg", pad_o, 1'b1);
      @(negedge clk_i); pol_i = 1'b0;
   endtask

   task automatic t_preload;
      set_mode(1'b1, 1'b0, 1'b0);
      pol_i = 1'b0; pt_i = 8'h04; preload_en_i = 1'b1; preload_val_i = 1'b0;
      @(posedge clk_i); #1;
      chk("R9 preload 0 beats sum 1", pad_o, 1'b0);
      @(negedge clk_i); pt_i = 8'h00; preload_val_i = 1'b1;
      @(posedge clk_i); #1;
      chk("R9 preload 1 beats sum 0", pad_o, 1'b1);
      @(negedge clk_i); preload_en_i = 1'b0; pt_i = 8'h00;
      @(posedge clk_i); #1;
      chk("R2 capture after preload", pad_o, 1'b0);
   endtask

   task automatic t_por_midrun;
      set_mode(1'b1, 1'b0, 1'b0);
      pt_i = 8'h08; pol_i = 1'b0;
      @(posedge clk_i); #1;
      chk("R2 hold one before clear", pad_o, 1'b1);
      por_ni = 1'b0; #0.5;
      chk("R8 async clear", pad_o, 1'b0);
      @(negedge clk_i); por_ni = 1'b1; #1;
      chk("R8 stays clear until edge", pad_o, 1'b0);
      @(posedge clk_i); #1;
      chk("R2 capture after clear", pad_o, 1'b1);
   endtask

   initial begin
      t_reset();
      t_registered();
      t_reg_oe();
      t_comb_out();
      t_comb_io();
      t_dedicated();
      t_polarity();
      t_preload();
      t_por_midrun();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk_i);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule